// File: doc/BRIEF.md
# Doorbell Mailbox with Wake Handshake

This block passes doorbell events from one processor (the sender) to another (the receiver). Each side has its own register frame on its own simple memory-mapped port: a select, a write flag, a 12-bit byte address and 32-bit write and read data, with reads returned in the same cycle. The two frames share no registers. A build-time number of one-way channels each hold a 32-bit status word. The sender raises bits in a channel. The receiver reads the word and clears the bits it has handled.

While a channel's status is non-zero, a level interrupt for that channel is high towards the receiver. A combined interrupt is the OR of all channel interrupts. The sender frame also holds a wake handshake. A request bit drives a wake output to the receiver side. A ready bit shows a synchronised copy of the receiver's awake signal, so the sender can wait before ringing. The mailbox only asks for wake-up. Dropping the request merely permits the receiver to sleep.

Each channel occupies a 32-byte window at `channel * 0x20`. Sender window: status at +0x00, raise-bits at +0x0C. Receiver window: status at +0x00, clear-bits at +0x08. Both frames report the channel count at 0xF80. Only the sender frame has the wake request at 0xF88 and the ready flag at 0xF8C.

Top module: `dbell_mailbox`

## Requirements
- R1: After a synchronous reset, every channel status reads 0, all channel interrupts and `any_irq` are 0, and `wake_req` is 0.
- R2: A sender write to window offset 0x0C ORs the written data into that channel's status from the next clock edge. Writing zero bits leaves the status unchanged.
- R3: A receiver write to window offset 0x08 clears exactly the status bits that are 1 in the written data. Bits written as 0 are unchanged.
- R4: When a raise and a clear hit the same channel in the same cycle, the status becomes (old AND NOT clear) OR raise, so the raise wins on a shared bit.
- R5: `ch_irq[i]` is 1 exactly when channel i's status is non-zero, and `any_irq` is the OR of all `ch_irq` bits.
- R6: Address 0xF80 reads the channel count `NUM_CH` in both frames.
- R7: A sender write to 0xF88 stores bit 0 of the data. That bit drives `wake_req` and reads back in bit 0 at 0xF88, with the other bits reading 0.
- R8: Sender address 0xF8C reads `rx_awake` in bit 0 through a two-flop synchroniser. A change is seen on the second clock edge after it, and not on the first.
- R9: The frames are isolated. Receiver writes to 0x0C, 0xF88 or 0xF8C, and sender writes to 0x08, change nothing. The receiver frame reads 0 at 0xF88 and 0xF8C.
- R10: Window offset 0x00 reads the channel status in both frames. Every other window offset, every window at or above `NUM_CH`, and every other unmapped address reads 0. Writes to any of these are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_sel | input | 1 | Sender frame access select |
| snd_wr | input | 1 | Sender access is a write |
| snd_addr | input | 12 | Sender byte address |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data (same cycle) |
| rcv_sel | input | 1 | Receiver frame access select |
| rcv_wr | input | 1 | Receiver access is a write |
| rcv_addr | input | 12 | Receiver byte address |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data (same cycle) |
| rx_awake | input | 1 | Receiver-domain awake indication |
| wake_req | output | 1 | Wake request towards the receiver |
| ch_irq | output | NUM_CH | Per-channel interrupt |
| any_irq | output | 1 | OR of all channel interrupts |

## Verification
Every channel gets a raise with several bit patterns: sparse, dense, shifted and overlapping with bits already set. This separates a true OR from an overwrite, and a wrong window decode from a right one. Partial clear masks, and writes of all zeros, tell a bitwise clear apart from a whole-word clear and show whether zero writes are ignored. Each status is read through both frames. The per-channel interrupts are compared after each step, so a crossed channel index shows up. A raise and a clear in the same cycle show the priority. Stray writes to the other frame's offsets, to out-of-range windows and to the wake registers show whether the frames are isolated. A step on `rx_awake` shows the two-edge ready latency.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int WIN_BITS = 5;
    localparam int IDX_W    = ADDR_W - WIN_BITS;

    localparam logic [ADDR_W-1:0] OFF_CAP = 12'hF80;
    localparam logic [ADDR_W-1:0] OFF_REQ = 12'hF88;
    localparam logic [ADDR_W-1:0] OFF_RDY = 12'hF8C;

    localparam logic [WIN_BITS-1:0] WIN_STAT = 5'h00;
    localparam logic [WIN_BITS-1:0] WIN_CLR  = 5'h08;
    localparam logic [WIN_BITS-1:0] WIN_SET  = 5'h0C;

    typedef enum logic {FRAME_SND = 1'b0, FRAME_RCV = 1'b1} frame_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [IDX_W-1:0] win_index(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WIN_BITS];
    endfunction

    function automatic logic [WIN_BITS-1:0] win_off(input logic [ADDR_W-1:0] a);
        return a[WIN_BITS-1:0];
    endfunction

endpackage

// File: rtl/dbell_chan.sv
module dbell_chan
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raise_bits,
    input  logic [DATA_W-1:0] clear_bits,
    output logic [DATA_W-1:0] status,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clear_bits) | raise_bits;
    end

    assign irq = |status;

    assert_raise_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(raise_bits)) == $past(raise_bits)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (raise_bits == '0) |=> ((status & $past(clear_bits)) == '0));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (raise_bits == '0 && clear_bits == '0) |=> $stable(status));

endmodule

// File: rtl/dbell_wake.sv
module dbell_wake
    import dbell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_we,
    input  logic req_wbit,
    input  logic rx_awake,
    output logic wake_req,
    output logic ready
);

    logic       sync_q1;
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_req  <= 1'b0;
            sync_q1   <= 1'b0;
            ready     <= 1'b0;
            since_rst <= '0;
        end else begin
            if (req_we) wake_req <= req_wbit;
            sync_q1 <= rx_awake;
            ready   <= sync_q1;
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
        end
    end

    assert_req_store_R7: assert property (@(posedge clk) disable iff (rst)
        req_we |=> (wake_req == $past(req_wbit)));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !req_we |=> $stable(wake_req));

    assert_sync_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (ready == $past(rx_awake, 2)));

endmodule

// File: rtl/dbell_frame.sv
module dbell_frame
    import dbell_pkg::*;
#(
    parameter int     NUM_CH = 4,
    parameter frame_e KIND   = FRAME_SND
) (
    input  bus_req_t                       req,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  status,
    input  logic                           wake_bit,
    input  logic                           ready_bit,
    output logic [NUM_CH-1:0][DATA_W-1:0]  op_bits,
    output logic                           req_we,
    output logic [DATA_W-1:0]              rdata
);

    localparam logic [WIN_BITS-1:0] OP_OFF  = (KIND == FRAME_SND) ? WIN_SET : WIN_CLR;
    localparam logic                HAS_WAKE = (KIND == FRAME_SND);
    localparam logic [DATA_W-1:0]   CAP_VAL = DATA_W'(NUM_CH);

    logic [IDX_W-1:0]    idx;
    logic [WIN_BITS-1:0] off;
    logic                wr_go;

    assign idx   = win_index(req.addr);
    assign off   = win_off(req.addr);
    assign wr_go = req.sel && req.wr;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_op
        assign op_bits[ch] = (wr_go && idx == IDX_W'(ch) && off == OP_OFF)
                             ? req.wdata : '0;
    end

    assign req_we = HAS_WAKE && wr_go && (req.addr == OFF_REQ);

    always_comb begin
        rdata = '0;
        if (req.sel) begin
            if (req.addr == OFF_CAP) begin
                rdata = CAP_VAL;
            end else if (HAS_WAKE && req.addr == OFF_REQ) begin
                rdata = {{(DATA_W-1){1'b0}}, wake_bit};
            end else if (HAS_WAKE && req.addr == OFF_RDY) begin
                rdata = {{(DATA_W-1){1'b0}}, ready_bit};
            end else if (off == WIN_STAT) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (idx == IDX_W'(ch)) rdata = status[ch];
                end
            end
        end
    end

endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snd_sel,
    input  logic              snd_wr,
    input  logic [11:0]       snd_addr,
    input  logic [31:0]       snd_wdata,
    output logic [31:0]       snd_rdata,
    input  logic              rcv_sel,
    input  logic              rcv_wr,
    input  logic [11:0]       rcv_addr,
    input  logic [31:0]       rcv_wdata,
    output logic [31:0]       rcv_rdata,
    input  logic              rx_awake,
    output logic              wake_req,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              any_irq
);

    bus_req_t snd_req, rcv_req;
    logic [NUM_CH-1:0][DATA_W-1:0] status, raise_v, clear_v;
    logic snd_req_we, rcv_req_we_unused, ready;

    assign snd_req = '{sel: snd_sel, wr: snd_wr, addr: snd_addr, wdata: snd_wdata};
    assign rcv_req = '{sel: rcv_sel, wr: rcv_wr, addr: rcv_addr, wdata: rcv_wdata};

    dbell_frame #(.NUM_CH(NUM_CH), .KIND(FRAME_SND)) u_snd (
        .req(snd_req), .status(status), .wake_bit(wake_req), .ready_bit(ready),
        .op_bits(raise_v), .req_we(snd_req_we), .rdata(snd_rdata)
    );

    dbell_frame #(.NUM_CH(NUM_CH), .KIND(FRAME_RCV)) u_rcv (
        .req(rcv_req), .status(status), .wake_bit(wake_req), .ready_bit(ready),
        .op_bits(clear_v), .req_we(rcv_req_we_unused), .rdata(rcv_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dbell_chan u_chan (
            .clk(clk), .rst(rst),
            .raise_bits(raise_v[ch]), .clear_bits(clear_v[ch]),
            .status(status[ch]), .irq(ch_irq[ch])
        );
    end

    dbell_wake u_wake (
        .clk(clk), .rst(rst), .req_we(snd_req_we), .req_wbit(snd_wdata[0]),
        .rx_awake(rx_awake), .wake_req(wake_req), .ready(ready)
    );

    assign any_irq = |ch_irq;

    assert_rcv_no_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (rcv_sel && rcv_wr && rcv_addr == OFF_REQ &&
         !(snd_sel && snd_wr && snd_addr == OFF_REQ)) |=> $stable(wake_req));

    assert_rcv_noop_R9: assert property (@(posedge clk) disable iff (rst)
        (rcv_req_we_unused == 1'b0));

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (ch_irq == '0 && !wake_req));

endmodule

// File: tb/dbell_mailbox_test.sv
module dbell_mailbox_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic snd_sel = 0, snd_wr = 0, rcv_sel = 0, rcv_wr = 0, rx_awake = 0;
    logic [11:0] snd_addr = 0, rcv_addr = 0;
    logic [31:0] snd_wdata = 0, rcv_wdata = 0, snd_rdata, rcv_rdata;
    logic wake_req, any_irq;
    logic [NCH-1:0] ch_irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] model [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_mailbox #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst),
        .snd_sel(snd_sel), .snd_wr(snd_wr), .snd_addr(snd_addr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .rcv_sel(rcv_sel), .rcv_wr(rcv_wr), .rcv_addr(rcv_addr),
        .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
        .rx_awake(rx_awake), .wake_req(wake_req), .ch_irq(ch_irq), .any_irq(any_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic swr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); snd_sel = 1; snd_wr = 1; snd_addr = a; snd_wdata = d;
        @(negedge clk); snd_sel = 0; snd_wr = 0;
    endtask

    task automatic rwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); rcv_sel = 1; rcv_wr = 1; rcv_addr = a; rcv_wdata = d;
        @(negedge clk); rcv_sel = 0; rcv_wr = 0;
    endtask

    task automatic srd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); snd_sel = 1; snd_wr = 0; snd_addr = a;
        #1 d = snd_rdata; snd_sel = 0;
    endtask

    task automatic rrd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rcv_sel = 1; rcv_wr = 0; rcv_addr = a;
        #1 d = rcv_rdata; rcv_sel = 0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [NCH-1:0] ei;
        for (int c = 0; c < NCH; c++) begin
            srd(12'(c * 32), d); chk({tag, " R10 snd stat"}, d, model[c]);
            rrd(12'(c * 32), d); chk({tag, " R10 rcv stat"}, d, model[c]);
            ei[c] = (model[c] != 0);
        end
        chk({tag, " R5 ch_irq"}, 32'(ch_irq), 32'(ei));
        chk({tag, " R5 any_irq"}, 32'(any_irq), 32'(|ei));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, pat, cm;
        for (int c = 0; c < NCH; c++) model[c] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 wake_req", 32'(wake_req), 0);
        chk("R1 ch_irq", 32'(ch_irq), 0);
        check_all("R1");
        // R6 capability in both frames
        srd(12'hF80, d); chk("R6 snd cap", d, NCH);
        rrd(12'hF80, d); chk("R6 rcv cap", d, NCH);

        // R2/R3 sweep: each channel, several patterns
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 4; k++) begin
                pat = (32'h0000_0001 << (c * 5 + k)) | ((32'hA5A5_0000 >> (k * 3)) ^ 32'(c << k));
                swr(12'(c * 32 + 12), pat);
                model[c] = model[c] | pat;
                check_all("R2 raise");
            end
            swr(12'(c * 32 + 12), 32'h0);
            check_all("R2 zero raise");
            cm = model[c] & (32'h0F0F_F0F0 >> c);
            rwr(12'(c * 32 + 8), cm);
            model[c] = model[c] & ~cm;
            check_all("R3 partial clear");
            rwr(12'(c * 32 + 8), 32'h0);
            check_all("R3 zero clear");
        end

        // R9 isolation: wrong offsets per frame
        swr(12'h008, 32'hFFFF_FFFF);
        rwr(12'h02C, 32'hFFFF_FFFF);
        check_all("R9 cross-offset");
        // R10 other offsets and windows ignore writes, read zero
        swr(12'h004, 32'hFFFF_FFFF);
        swr(12'(NCH * 32 + 12), 32'hFFFF_FFFF);
        rwr(12'(NCH * 32 + 8), 32'hFFFF_FFFF);
        check_all("R10 stray write");
        srd(12'(NCH * 32), d); chk("R10 snd out-of-range", d, 0);
        rrd(12'(NCH * 32), d); chk("R10 rcv out-of-range", d, 0);
        srd(12'h00C, d); chk("R10 snd set offset reads 0", d, 0);
        rrd(12'h008, d); chk("R10 rcv clr offset reads 0", d, 0);
        srd(12'hF84, d); chk("R10 snd unmapped", d, 0);

        // R4 simultaneous raise and clear on channel 1
        @(negedge clk);
        snd_sel = 1; snd_wr = 1; snd_addr = 12'h02C; snd_wdata = 32'h0000_FF00;
        rcv_sel = 1; rcv_wr = 1; rcv_addr = 12'h028; rcv_wdata = 32'h00FF_FF00 | model[1];
        @(negedge clk);
        snd_sel = 0; snd_wr = 0; rcv_sel = 0; rcv_wr = 0;
        model[1] = (model[1] & ~(32'h00FF_FF00 | model[1])) | 32'h0000_FF00;
        check_all("R4 collide");

        // R3 clear all channels
        for (int c = 0; c < NCH; c++) begin
            rwr(12'(c * 32 + 8), model[c]);
            model[c] = 0;
        end
        check_all("R3 clear all");

        // R7 wake request
        swr(12'hF88, 32'hFFFF_FFFF);
        chk("R7 wake_req set", 32'(wake_req), 1);
        srd(12'hF88, d); chk("R7 readback", d, 1);
        rwr(12'hF88, 32'h0);
        chk("R9 rcv write ignored", 32'(wake_req), 1);
        rrd(12'hF88, d); chk("R9 rcv F88 reads 0", d, 0);
        swr(12'hF88, 32'hFFFF_FFFE);
        chk("R7 wake_req cleared", 32'(wake_req), 0);
        rwr(12'hF88, 32'h1);
        chk("R9 rcv cannot raise wake", 32'(wake_req), 0);

        // R8 ready synchroniser latency
        @(negedge clk); rx_awake = 1;
        @(negedge clk); snd_sel = 1; snd_wr = 0; snd_addr = 12'hF8C;
        #1 chk("R8 after one edge", snd_rdata, 0);
        @(negedge clk); #1 chk("R8 after two edges", snd_rdata, 1);
        snd_sel = 0;
        rrd(12'hF8C, d); chk("R9 rcv F8C reads 0", d, 0);
        swr(12'hF8C, 32'h0);
        srd(12'hF8C, d); chk("R8 ready not writable", d, 1);
        @(negedge clk); rx_awake = 0;
        repeat (2) @(negedge clk);
        srd(12'hF8C, d); chk("R8 ready falls", d, 0);

        // R1 reset again clears state
        swr(12'h00C, 32'h1);
        swr(12'hF88, 32'h1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model[0] = 0;
        chk("R1 wake after reset", 32'(wake_req), 0);
        check_all("R1 re-reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule